// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer with Interrupt Escalation

This block is a watchdog counter that software keeps from expiring by writing a two-value key sequence to a service register. The counter advances on a prescaled tick input while it is enabled. When it reaches the selected period, the block takes one of two actions, chosen by a control bit. It either requests an internal reset and records why, or it raises an interrupt. In interrupt mode, if a second expiry arrives while the interrupt is still unacknowledged and escalation is enabled, the block sends a one-cycle forced transfer-acknowledge pulse. This pulse frees a stalled bus cycle so that the acknowledge cycle can proceed, and a sticky flag records the event.

Software reaches the block through a small register port. The control register lives at address 0, the service register at address 1 and the reset-status register at address 2. Reads are combinational. Writes take effect at the clock edge.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, irq_o, rst_req_o and fack_o are low, the control register reads 0 (counter disabled) and the reset-status register reads 0.
- R2: While control bit 0 (enable) is clear, ticks do not advance the counter and no expiry action occurs.
- R3: Control bits 5:3 hold a period select n. With enable set and the counter restarted, the expiry action happens on tick number 2^(BASE_EXP+EXP_STEP*n) and not before. The counter then restarts from zero.
- R4: A write of 0x55 to address 1, followed later by a write of 0xAA to address 1, restarts the counter. Any accesses to other addresses may come between the two writes.
- R5: A service write of any value other than 0x55 or 0xAA disarms the sequence, and so does 0xAA with no armed 0x55. A repeated 0x55 keeps the sequence armed.
- R6: When control bit 1 (action) is 0, expiry sets irq_o. irq_o then stays high until irq_ack_i is high at a clock edge or a completed key sequence restarts the counter.
- R7: When control bit 1 is 1, expiry drives rst_req_o high for exactly one cycle and sets reset-status bit 0. Writing 1 to reset-status bit 0 clears it.
- R8: In interrupt mode with control bit 2 (escalate) set, an expiry while irq_o is still high and no acknowledge is present drives fack_o for exactly one cycle. It also sets control bit 7, and writing 1 to that bit clears it.
- R9: With control bit 2 clear, a second expiry while irq_o is high produces no fack_o and leaves control bit 7 clear.
- R10: While irq_o is high, writes to the control register are ignored, including the clear of bit 7. Once irq_o is low, control writes take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 control, 1 service, 2 reset status) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| tick_i | input | 1 | Prescaled count enable |
| irq_ack_i | input | 1 | Interrupt-acknowledge pulse |
| irq_o | output | 1 | Watchdog interrupt |
| rst_req_o | output | 1 | Internal reset request, one-cycle pulse |
| fack_o | output | 1 | Forced transfer acknowledge, one-cycle pulse |

## Verification
The bench builds the block with BASE_EXP=2 and EXP_STEP=1, so the eight selectable periods become 4, 8, up to 512 ticks instead of 2^9 to 2^23. With these values, every period select can be walked to its exact expiry tick within a short run. Second-expiry escalation and reset-mode behaviour can also be reached in a few dozen ticks. SEL_W keeps its default of 3, so the full control-field decode is exercised.

// File: rtl/svc_wdog_pkg.sv
package svc_wdog_pkg;
   // register addresses
   localparam int unsigned ADR_CTRL  = 0;
   localparam int unsigned ADR_SVC   = 1;
   localparam int unsigned ADR_RSTAT = 2;

   // service keys: arm first, then fire
   localparam logic [7:0] KEY_ARM  = 8'h55;
   localparam logic [7:0] KEY_FIRE = 8'hAA;

   // control register bit positions
   localparam int unsigned CB_EN      = 0;
   localparam int unsigned CB_ACT_RST = 1;
   localparam int unsigned CB_ESC     = 2;
   localparam int unsigned CB_SEL_LSB = 3;
   localparam int unsigned CB_FLAG    = 7;

   // reset-status bit positions
   localparam int unsigned SB_CAUSE = 0;

   typedef enum logic {ACT_IRQ = 1'b0, ACT_RESET = 1'b1} wdog_act_e;
endpackage

// File: rtl/wdog_keyseq.sv
module wdog_keyseq #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              svc_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              svc_hit
);
   import svc_wdog_pkg::*;

   localparam logic [DATA_W-1:0] ARM_V  = DATA_W'(KEY_ARM);
   localparam logic [DATA_W-1:0] FIRE_V = DATA_W'(KEY_FIRE);

   logic armed_q;
   logic is_arm;
   logic is_fire;

   always_comb begin
      is_arm  = (wdata == ARM_V);
      is_fire = (wdata == FIRE_V);
      svc_hit = svc_wr && armed_q && is_fire;
   end

   // every service write re-decides the armed state: only 0x55 leaves it set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (svc_wr) begin
         armed_q <= is_arm;
      end
   end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned BASE_EXP = 9,
   parameter int unsigned EXP_STEP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic             expire
);
   localparam int unsigned NPER  = 1 << SEL_W;
   localparam int unsigned MAX_E = BASE_EXP + EXP_STEP * (NPER - 1);
   localparam int unsigned CNT_W = (MAX_E < 1) ? 1 : MAX_E;

   logic [CNT_W-1:0] lim_tab [NPER];
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   // one terminal count per period select, built at elaboration
   for (genvar n = 0; n < NPER; n++) begin : g_lim
      localparam int unsigned EXP_N = BASE_EXP + EXP_STEP * n;
      assign lim_tab[n] = CNT_W'((64'd1 << EXP_N) - 64'd1);
   end

   always_comb begin
      lim    = lim_tab[sel];
      // >= so a shortened period still expires on the next tick
      expire = en && tick && !restart && (cnt_q >= lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (en && tick) begin
         cnt_q <= expire ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic act_rst,
   input  logic esc_en,
   input  logic ack,
   input  logic svc,
   input  logic flag_clr,
   input  logic cause_clr,
   output logic irq,
   output logic rst_req,
   output logic fack,
   output logic fack_flag,
   output logic rst_cause
);
   logic first_to;
   logic second_to;
   logic reset_to;

   always_comb begin
      first_to  = expire && !act_rst && !irq;
      second_to = expire && !act_rst && irq && !ack && esc_en;
      reset_to  = expire && act_rst;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq       <= 1'b0;
         rst_req   <= 1'b0;
         fack      <= 1'b0;
         fack_flag <= 1'b0;
         rst_cause <= 1'b0;
      end else begin
         // acknowledge or service withdraws a pending interrupt
         if (irq && (ack || svc)) begin
            irq <= 1'b0;
         end else if (first_to) begin
            irq <= 1'b1;
         end
         fack    <= second_to;
         rst_req <= reset_to;
         // a set in the same cycle as a clear wins
         if (second_to) begin
            fack_flag <= 1'b1;
         end else if (flag_clr) begin
            fack_flag <= 1'b0;
         end
         if (reset_to) begin
            rst_cause <= 1'b1;
         end else if (cause_clr) begin
            rst_cause <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog #(
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned BASE_EXP = 9,
   parameter int unsigned EXP_STEP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tick_i,
   input  logic              irq_ack_i,
   output logic              irq_o,
   output logic              rst_req_o,
   output logic              fack_o
);
   import svc_wdog_pkg::*;

   localparam int unsigned SEL_MSB = CB_SEL_LSB + SEL_W - 1;

   // elaboration-time parameter checks
   if (DATA_W < 8) begin : g_bad_data
      $error("svc_watchdog: DATA_W must be at least 8");
   end
   if (SEL_W < 1 || SEL_MSB >= CB_FLAG) begin : g_bad_sel
      $error("svc_watchdog: SEL_W must fit below the flag bit");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("svc_watchdog: ADDR_W must be at least 2");
   end
   if (BASE_EXP + EXP_STEP * ((1 << SEL_W) - 1) > 62) begin : g_bad_exp
      $error("svc_watchdog: longest period exceeds 2^62");
   end

   // configuration state
   logic             cfg_en_q;
   wdog_act_e        cfg_act_q;
   logic             cfg_esc_q;
   logic [SEL_W-1:0] cfg_sel_q;

   logic wr_ctrl, wr_svc, wr_rstat;
   logic ctrl_ok;
   logic svc_hit;
   logic expire;
   logic fack_flag;
   logic rst_cause;

   always_comb begin
      wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(ADR_CTRL));
      wr_svc   = reg_wr && (reg_addr == ADDR_W'(ADR_SVC));
      wr_rstat = reg_wr && (reg_addr == ADDR_W'(ADR_RSTAT));
      // control locked while an expiry is pending
      ctrl_ok  = wr_ctrl && !irq_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en_q  <= 1'b0;
         cfg_act_q <= ACT_IRQ;
         cfg_esc_q <= 1'b0;
         cfg_sel_q <= '0;
      end else if (ctrl_ok) begin
         cfg_en_q  <= reg_wdata[CB_EN];
         cfg_act_q <= wdog_act_e'(reg_wdata[CB_ACT_RST]);
         cfg_esc_q <= reg_wdata[CB_ESC];
         cfg_sel_q <= reg_wdata[SEL_MSB:CB_SEL_LSB];
      end
   end

   wdog_keyseq #(.DATA_W(DATA_W)) u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .svc_wr  (wr_svc),
      .wdata   (reg_wdata),
      .svc_hit (svc_hit)
   );

   wdog_count #(
      .SEL_W    (SEL_W),
      .BASE_EXP (BASE_EXP),
      .EXP_STEP (EXP_STEP)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cfg_en_q),
      .tick    (tick_i),
      .restart (svc_hit),
      .sel     (cfg_sel_q),
      .expire  (expire)
   );

   wdog_escalate u_esc (
      .clk       (clk),
      .rst_n     (rst_n),
      .expire    (expire),
      .act_rst   (cfg_act_q == ACT_RESET),
      .esc_en    (cfg_esc_q),
      .ack       (irq_ack_i),
      .svc       (svc_hit),
      .flag_clr  (ctrl_ok && reg_wdata[CB_FLAG]),
      .cause_clr (wr_rstat && reg_wdata[SB_CAUSE]),
      .irq       (irq_o),
      .rst_req   (rst_req_o),
      .fack      (fack_o),
      .fack_flag (fack_flag),
      .rst_cause (rst_cause)
   );

   // combinational read mux
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(ADR_CTRL)) begin
         reg_rdata[CB_EN]                = cfg_en_q;
         reg_rdata[CB_ACT_RST]           = (cfg_act_q == ACT_RESET);
         reg_rdata[CB_ESC]               = cfg_esc_q;
         reg_rdata[SEL_MSB:CB_SEL_LSB]   = cfg_sel_q;
         reg_rdata[CB_FLAG]              = fack_flag;
      end else if (reg_addr == ADDR_W'(ADR_RSTAT)) begin
         reg_rdata[SB_CAUSE]             = rst_cause;
      end
   end
endmodule

module svc_watchdog_chk #(
   parameter int unsigned SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq,
   input logic             ack,
   input logic             svc,
   input logic             rst_req,
   input logic             fack,
   input logic             cause,
   input logic             flag,
   input logic             en,
   input logic [SEL_W-1:0] sel
);
   assert_irq_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> en);
   assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack && !svc) |=> irq);
   assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);
   assert_rst_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> cause);
   assert_fack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fack |=> !fack);
   assert_fack_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fack |-> (flag && irq));
   assert_ctrl_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> ($stable(en) && $stable(sel)));
   assert_no_mix_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_req && fack));
endmodule

bind svc_watchdog svc_watchdog_chk #(.SEL_W(SEL_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq     (irq_o),
   .ack     (irq_ack_i),
   .svc     (svc_hit),
   .rst_req (rst_req_o),
   .fack    (fack_o),
   .cause   (rst_cause),
   .flag    (fack_flag),
   .en      (cfg_en_q),
   .sel     (cfg_sel_q)
);

// File: tb/svc_watchdog_bench.sv
module svc_watchdog_bench;
   localparam int AW = 2;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          tick_i = 1'b0;
   logic          irq_ack_i = 1'b0;
   logic          irq_o, rst_req_o, fack_o;

   int checks = 0;
   int fails  = 0;

   // period select -> expected ticks until expiry with BASE_EXP=2, EXP_STEP=1
   localparam int NV = 8;
   localparam int unsigned PERIOD_TAB [NV] = '{4, 8, 16, 32, 64, 128, 256, 512};

   svc_watchdog #(.ADDR_W(AW), .DATA_W(DW), .SEL_W(3), .BASE_EXP(2), .EXP_STEP(1)) u_svc_watchdog (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_i(tick_i),
      .irq_ack_i(irq_ack_i), .irq_o(irq_o), .rst_req_o(rst_req_o), .fack_o(fack_o)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk);
      reg_addr = AW'(a);
      #1 v = int'(reg_rdata);
   endtask

   task automatic ticks(input int k);
      for (int i = 0; i < k; i++) begin
         @(negedge clk); tick_i = 1'b1;
         @(negedge clk); tick_i = 1'b0;
      end
   endtask

   task automatic ack();
      @(negedge clk); irq_ack_i = 1'b1;
      @(negedge clk); irq_ack_i = 1'b0;
   endtask

   task automatic service();
      wr(1, 8'h55);
      wr(1, 8'hAA);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: run hung actual=1 expected=0");
      finish_run();
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", irq_o, 0);
      chk("R1 rst_req", rst_req_o, 0);
      chk("R1 fack", fack_o, 0);
      rd(0, v); chk("R1 ctrl", v, 0);
      rd(2, v); chk("R1 rstat", v, 0);

      // R2 disabled: ticks do nothing
      ticks(20);
      chk("R2 irq while disabled", irq_o, 0);
      chk("R2 rst_req while disabled", rst_req_o, 0);

      // R3 table walk over every period select
      for (int i = 0; i < NV; i++) begin
         wr(0, 1 | (i << 3));
         service();
         ticks(int'(PERIOD_TAB[i]) - 1);
         chk($sformatf("R3 sel%0d early", i), irq_o, 0);
         ticks(1);
         chk($sformatf("R3 sel%0d expiry", i), irq_o, 1);
         ack();
         chk($sformatf("R6 sel%0d ack clears", i), irq_o, 0);
      end

      // R4 keys with other accesses in between
      wr(0, 8'h01);
      service();
      ticks(3);
      wr(1, 8'h55);
      rd(0, v);
      wr(2, 8'h00);
      wr(1, 8'hAA);
      ticks(3);
      chk("R4 interleaved service restarts", irq_o, 0);
      ticks(1);
      chk("R4 expiry after restart", irq_o, 1);
      ack();

      // R5 wrong value disarms
      service();
      ticks(3);
      wr(1, 8'h55); wr(1, 8'h12); wr(1, 8'hAA);
      ticks(1);
      chk("R5 wrong key disarms", irq_o, 1);
      ack();
      // R5 lone 0xAA does nothing
      service();
      ticks(3);
      wr(1, 8'hAA);
      ticks(1);
      chk("R5 lone fire key", irq_o, 1);
      ack();
      // R5 repeated arm stays armed
      service();
      ticks(3);
      wr(1, 8'h55); wr(1, 8'h55); wr(1, 8'hAA);
      ticks(3);
      chk("R5 repeated arm", irq_o, 0);
      ticks(1);
      chk("R5 repeated arm expiry", irq_o, 1);

      // R6 hold then service clears
      repeat (10) @(negedge clk);
      chk("R6 irq held", irq_o, 1);
      // R10 control locked while pending
      wr(0, 8'h00);
      rd(0, v); chk("R10 ctrl write refused", v, 8'h01);
      service();
      chk("R6 service clears irq", irq_o, 0);
      wr(0, 8'h00);
      rd(0, v); chk("R10 ctrl write accepted", v, 8'h00);

      // R8 escalation
      wr(0, 8'h05);
      service();
      ticks(4);
      chk("R8 first expiry irq", irq_o, 1);
      ticks(3);
      chk("R8 no fack early", fack_o, 0);
      ticks(1);
      chk("R8 fack asserted", fack_o, 1);
      @(negedge clk);
      chk("R8 fack one cycle", fack_o, 0);
      rd(0, v); chk("R8 sticky flag", v, 8'h85);
      wr(0, 8'h85);
      rd(0, v); chk("R10 flag clear refused", v, 8'h85);
      ack();
      wr(0, 8'h85);
      rd(0, v); chk("R8 flag W1C", v, 8'h05);

      // R9 no escalation when disabled
      wr(0, 8'h01);
      service();
      ticks(8);
      chk("R9 irq set", irq_o, 1);
      chk("R9 no fack", fack_o, 0);
      rd(0, v); chk("R9 flag clear", v, 8'h01);
      ack();

      // R7 reset mode
      wr(0, 8'h03);
      service();
      ticks(4);
      chk("R7 rst_req", rst_req_o, 1);
      chk("R7 no irq", irq_o, 0);
      @(negedge clk);
      chk("R7 rst_req one cycle", rst_req_o, 0);
      rd(2, v); chk("R7 cause set", v, 1);
      wr(2, 1);
      rd(2, v); chk("R7 cause W1C", v, 0);

      finish_run();
   end
endmodule